// File: doc/BRIEF.md
# Ping-Pong Peak-Hold Sequencer

This block sequences two analog peak-detect-and-hold cells so that together they work as a two-entry, event-driven FIFO of held peak voltages. In the alternating mode, every accepted event edge gives the two cells opposite roles. The cell that becomes the writer first receives a short clear strobe and then a write strobe, so that it captures the next peak. The other cell holds its read strobe and presents the previous peak to a downstream ADC until the next event arrives. The writer's clear time therefore falls inside the shaper's rise time, and the reader's window is as long as the gap between events. Two piled-up events are both kept, with no dead time between them.

The event source is selectable: an asynchronous trigger from the timing discriminator, or an external reset input. A paired mode ties cell A to writing and cell B to buffering. In that mode both cells are cleared only by the external input. The block also produces the preamplifier's fixed-width fast-reset pulse and its complement. Trigger edges that land while that pulse is high are discarded. All asynchronous inputs pass through a synchroniser and a rising-edge detector. Durations are cycle counts derived from the clock period.

Top module: `pkhold_seq`

## Requirements
- R1: While `rst` is high and on the first sample after it is released, all six cell strobes, `ev_valid`, `buf_sel`, `overrun` and `frst` are low and `frst_n` is high.
- R2: With `paired_mode`=0 and `src_ext`=0, the first trigger rising edge after reset makes cell A the writer. Each later accepted edge swaps the roles. A cell never drives its write and read strobes together.
- R3: After an accepted edge, the new writer's clear strobe is high for exactly RST_CYC cycles (18 by default), and its write strobe follows immediately. The clear and write strobes of one cell are never high together.
- R4: The reader's read strobe stays high without a break until the next accepted edge, however long the gap is.
- R5: `ev_valid` is a one-cycle pulse on each role swap, and it does not pulse on the first edge after reset. `buf_sel` names the cell being read: 0 for A, 1 for B.
- R6: With `src_ext`=1 in the alternating mode, rising edges of `ext_rst_in` drive the sequence and trigger edges have no effect.
- R7: With `paired_mode`=1, `a_wr` and `b_rd` are held high and `a_rd` and `b_wr` are held low, with `buf_sel`=1. Triggers have no effect. A rising edge of `ext_rst_in` raises `a_rst` and `b_rst` together for RST_CYC cycles, and `a_wr` is low during that time.
- R8: A rising edge of `fr_req` while `fr_en`=1 gives a `frst` pulse of exactly FR_CYC cycles (16 by default), with `frst_n` its inverse on every cycle. With `fr_en`=0 the request has no effect.
- R9: A trigger edge that arrives while `frst` is high causes no swap, no clear strobe and no `ev_valid`.
- R10: An accepted edge that arrives while the writer's clear is still counting swaps the roles at once and sets `overrun`. `overrun` stays set until reset.
- R11: A trigger held high counts as one event; only its rising edge is acted on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig_in | input | 1 | Asynchronous event trigger from the timing discriminator |
| ext_rst_in | input | 1 | Asynchronous external reset request |
| paired_mode | input | 1 | 1: A always writes and B always buffers; 0: the cells alternate |
| src_ext | input | 1 | Event source in the alternating mode: 1 external input, 0 trigger |
| fr_en | input | 1 | Enables fast-reset requests |
| fr_req | input | 1 | Asynchronous fast-reset request from saturation detection |
| a_wr | output | 1 | Cell A write strobe |
| a_rd | output | 1 | Cell A read strobe |
| a_rst | output | 1 | Cell A clear strobe |
| b_wr | output | 1 | Cell B write strobe |
| b_rd | output | 1 | Cell B read strobe |
| b_rst | output | 1 | Cell B clear strobe |
| ev_valid | output | 1 | One-cycle pulse when a held peak becomes readable |
| buf_sel | output | 1 | Cell holding the readable peak (0 A, 1 B) |
| overrun | output | 1 | Sticky flag: a held value was lost to an early event |
| frst | output | 1 | Fast-reset pulse to the preamplifier |
| frst_n | output | 1 | Complement of `frst` |

## Verification
The hardest case to reach is a trigger edge that lands inside the fast-reset window. The veto uses the synchronised view of both signals, and each passes through its own synchroniser. The bench raises the fast-reset request and raises a short trigger four cycles later, so that the trigger's detected edge falls in the middle of the 16-cycle pulse. It then checks that the writer's strobes have not changed, and sends a clean trigger afterwards to show that the next event is accepted. The overrun case is reached in a similar way: a second trigger is placed six cycles after the first, well inside the 18-cycle clear.

// File: rtl/pkhold_pkg.sv
package pkhold_pkg;

   typedef enum logic {
      CELL_A = 1'b0,
      CELL_B = 1'b1
   } cell_e;

   typedef struct packed {
      logic wr;
      logic rd;
      logic clr;
   } cell_strobe_t;

   function automatic int cyc_from_ps(input int dur_ps, input int clk_ps);
      return (dur_ps + clk_ps - 1) / clk_ps;
   endfunction

endpackage

// File: rtl/pkhold_sync_edge.sv
module pkhold_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   output logic rise
);
   initial assert (STAGES >= 2) else $fatal(1, "pkhold_sync_edge: STAGES must be at least 2");

   logic [STAGES:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-1:0], async_in};
   end

   assign rise = chain[STAGES-1] & ~chain[STAGES];

   a_r11_single_strobe: assert property (@(posedge clk) disable iff (rst)
      rise |=> !rise);

endmodule

// File: rtl/pkhold_oneshot.sv
module pkhold_oneshot #(
   parameter int CYC    = 16,
   parameter bit RETRIG = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic fire,
   output logic busy
);
   initial assert (CYC >= 1) else $fatal(1, "pkhold_oneshot: CYC must be at least 1");

   localparam int CW = $clog2(CYC + 1);
   localparam logic [CW-1:0] LOAD = CW'(CYC);

   logic [CW-1:0] cnt;
   logic          load;

   generate
      if (RETRIG) begin : g_retrig
         assign load = fire;
      end else begin : g_single
         assign load = fire && (cnt == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst)              cnt <= '0;
      else if (load)        cnt <= LOAD;
      else if (cnt != '0)   cnt <= cnt - 1'b1;
   end

   assign busy = (cnt != '0);

   a_r8_fire_starts: assert property (@(posedge clk) disable iff (rst)
      (fire && !busy) |=> busy);

endmodule

// File: rtl/pkhold_role_ctrl.sv
module pkhold_role_ctrl
   import pkhold_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic ev_acc,
   input  logic paired,
   input  logic clr_busy,
   output cell_strobe_t [1:0] strobes,
   output logic ev_valid,
   output logic buf_sel,
   output logic overrun
);
   cell_e               writer;
   logic                active;
   cell_strobe_t [1:0]  nx;
   logic                nx_buf;
   logic                widx;

   assign widx = writer;

   always_comb begin
      nx     = '0;
      nx_buf = 1'b0;
      if (paired) begin
         nx[CELL_A].clr = clr_busy;
         nx[CELL_B].clr = clr_busy;
         nx[CELL_A].wr  = !clr_busy;
         nx[CELL_B].rd  = 1'b1;
         nx_buf         = 1'b1;
      end else if (active) begin
         nx[widx].clr  = clr_busy;
         nx[widx].wr   = !clr_busy;
         nx[~widx].rd  = 1'b1;
         nx_buf        = ~widx;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         writer   <= CELL_A;
         active   <= 1'b0;
         ev_valid <= 1'b0;
         overrun  <= 1'b0;
         strobes  <= '0;
         buf_sel  <= 1'b0;
      end else begin
         ev_valid <= ev_acc && active;
         if (ev_acc) begin
            if (active) begin
               writer <= (writer == CELL_A) ? CELL_B : CELL_A;
               if (clr_busy) overrun <= 1'b1;
            end else begin
               active <= 1'b1;
            end
         end
         strobes <= nx;
         buf_sel <= nx_buf;
      end
   end

   a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
      overrun |=> overrun);

   a_r5_valid_single: assert property (@(posedge clk) disable iff (rst)
      ev_valid |=> !ev_valid);

endmodule

// File: rtl/pkhold_seq.sv
module pkhold_seq
   import pkhold_pkg::*;
#(
   parameter int CLK_PS      = 2500,
   parameter int CLR_PS      = 45000,
   parameter int FR_PS       = 40000,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic trig_in,
   input  logic ext_rst_in,
   input  logic paired_mode,
   input  logic src_ext,
   input  logic fr_en,
   input  logic fr_req,
   output logic a_wr,
   output logic a_rd,
   output logic a_rst,
   output logic b_wr,
   output logic b_rd,
   output logic b_rst,
   output logic ev_valid,
   output logic buf_sel,
   output logic overrun,
   output logic frst,
   output logic frst_n
);
   localparam int RST_CYC = cyc_from_ps(CLR_PS, CLK_PS);
   localparam int FR_CYC  = cyc_from_ps(FR_PS, CLK_PS);

   initial assert (CLK_PS > 0) else $fatal(1, "pkhold_seq: CLK_PS must be positive");

   logic trig_rise, ext_rise, fr_rise;
   logic fr_busy, clr_busy;
   logic src_rise, ev_acc, clr_fire;
   cell_strobe_t [1:0] strobes;

   pkhold_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_trig (
      .clk(clk), .rst(rst), .async_in(trig_in), .rise(trig_rise));
   pkhold_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_ext (
      .clk(clk), .rst(rst), .async_in(ext_rst_in), .rise(ext_rise));
   pkhold_sync_edge #(.STAGES(SYNC_STAGES)) u_sync_fr (
      .clk(clk), .rst(rst), .async_in(fr_req), .rise(fr_rise));

   pkhold_oneshot #(.CYC(FR_CYC), .RETRIG(1'b0)) u_fast_rst (
      .clk(clk), .rst(rst), .fire(fr_rise & fr_en), .busy(fr_busy));

   assign src_rise = src_ext ? ext_rise : (trig_rise & ~fr_busy);
   assign ev_acc   = ~paired_mode & src_rise;
   assign clr_fire = ev_acc | (paired_mode & ext_rise);

   pkhold_oneshot #(.CYC(RST_CYC), .RETRIG(1'b1)) u_clr_timer (
      .clk(clk), .rst(rst), .fire(clr_fire), .busy(clr_busy));

   pkhold_role_ctrl u_roles (
      .clk(clk), .rst(rst), .ev_acc(ev_acc), .paired(paired_mode),
      .clr_busy(clr_busy), .strobes(strobes), .ev_valid(ev_valid),
      .buf_sel(buf_sel), .overrun(overrun));

   assign a_wr   = strobes[CELL_A].wr;
   assign a_rd   = strobes[CELL_A].rd;
   assign a_rst  = strobes[CELL_A].clr;
   assign b_wr   = strobes[CELL_B].wr;
   assign b_rd   = strobes[CELL_B].rd;
   assign b_rst  = strobes[CELL_B].clr;
   assign frst   = fr_busy;
   assign frst_n = ~fr_busy;

   a_r3_a_clr_excl: assert property (@(posedge clk) disable iff (rst) !(a_rst && a_wr));
   a_r3_b_clr_excl: assert property (@(posedge clk) disable iff (rst) !(b_rst && b_wr));
   a_r2_a_one_role: assert property (@(posedge clk) disable iff (rst) !(a_wr && a_rd));
   a_r2_b_one_role: assert property (@(posedge clk) disable iff (rst) !(b_wr && b_rd));

   a_r8_needs_enable: assert property (@(posedge clk) disable iff (rst)
      $rose(frst) |-> $past(fr_en));

   a_r9_veto: assert property (@(posedge clk) disable iff (rst)
      (!paired_mode && !src_ext && trig_rise && fr_busy) |=> !ev_valid);

   a_r7_paired_roles: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(paired_mode) && !$past(clr_busy)) |-> (a_wr && b_rd && !a_rd && !b_wr));

endmodule

// File: tb/pkhold_seq_tb_top.sv
module pkhold_seq_tb_top;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst, trig_in, ext_rst_in, paired_mode, src_ext, fr_en, fr_req;
   logic a_wr, a_rd, a_rst, b_wr, b_rd, b_rst, ev_valid, buf_sel, overrun, frst, frst_n;

   int n_chk = 0, n_err = 0;
   bit done = 0;
   int c_arst, c_brst, c_awr, c_bwr, c_ard_low, c_ev, c_ovl, c_fr, c_frn_bad;

   pkhold_seq dut_i (
      .clk(clk), .rst(rst), .trig_in(trig_in), .ext_rst_in(ext_rst_in),
      .paired_mode(paired_mode), .src_ext(src_ext), .fr_en(fr_en), .fr_req(fr_req),
      .a_wr(a_wr), .a_rd(a_rd), .a_rst(a_rst), .b_wr(b_wr), .b_rd(b_rd), .b_rst(b_rst),
      .ev_valid(ev_valid), .buf_sel(buf_sel), .overrun(overrun), .frst(frst), .frst_n(frst_n));

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic bit win(input int i, input int s, input int l);
      return (s >= 0) && (i >= s) && (i < s + l);
   endfunction

   task automatic run(input int t1, input int l1, input int t2, input int l2,
                      input int e1, input int el, input int f1, input int fl, input int total);
      c_arst = 0; c_brst = 0; c_awr = 0; c_bwr = 0; c_ard_low = 0;
      c_ev = 0; c_ovl = 0; c_fr = 0; c_frn_bad = 0;
      for (int i = 0; i < total; i++) begin
         @(negedge clk);
         c_arst    += int'(a_rst);
         c_brst    += int'(b_rst);
         c_awr     += int'(a_wr);
         c_bwr     += int'(b_wr);
         c_ard_low += int'(!a_rd);
         c_ev      += int'(ev_valid);
         c_ovl     += int'((a_rst && a_wr) || (b_rst && b_wr));
         c_fr      += int'(frst);
         c_frn_bad += int'(frst_n == frst);
         trig_in    = win(i, t1, l1) || win(i, t2, l2);
         ext_rst_in = win(i, e1, el);
         fr_req     = win(i, f1, fl);
      end
      @(negedge clk);
      trig_in = 0; ext_rst_in = 0; fr_req = 0;
   endtask

   task automatic do_reset(input bit paired, input bit ext);
      @(negedge clk);
      rst = 1; trig_in = 0; ext_rst_in = 0; fr_req = 0;
      paired_mode = paired; src_ext = ext;
      repeat (3) @(negedge clk);
      rst = 0;
   endtask

   task automatic t_reset_state();
      do_reset(0, 0);
      chk("R1 strobes", int'({a_wr, a_rd, a_rst, b_wr, b_rd, b_rst}), 0);
      chk("R1 flags", int'({ev_valid, buf_sel, overrun, frst}), 0);
      chk("R1 frst_n", int'(frst_n), 1);
   endtask

   task automatic t_alternate();
      run(0, 2, -1, 0, -1, 0, -1, 0, 40);
      chk("R3 A clear width", c_arst, 18);
      chk("R3 clear/write overlap", c_ovl, 0);
      chk("R5 no valid on first event", c_ev, 0);
      chk("R2 A writes first", int'(a_wr), 1);
      chk("R2 B reads", int'(b_rd && !b_wr), 1);
      chk("R5 buf_sel B", int'(buf_sel), 1);
      run(0, 2, -1, 0, -1, 0, -1, 0, 40);
      chk("R3 B clear width", c_brst, 18);
      chk("R5 one valid per swap", c_ev, 1);
      chk("R2 swap to B write", int'(b_wr && !a_wr), 1);
      chk("R2 A reads", int'(a_rd), 1);
      chk("R5 buf_sel A", int'(buf_sel), 0);
      chk("R10 no overrun", int'(overrun), 0);
   endtask

   task automatic t_long_gap();
      run(-1, 0, -1, 0, -1, 0, -1, 0, 200);
      chk("R4 read held", c_ard_low, 0);
      chk("R4 writer held", c_bwr, 200);
   endtask

   task automatic t_held_trigger();
      run(0, 60, -1, 0, -1, 0, -1, 0, 80);
      chk("R11 one event", c_ev, 1);
      chk("R11 one clear", c_arst, 18);
      chk("R11 A writes", int'(a_wr), 1);
   endtask

   task automatic t_overrun();
      do_reset(0, 0);
      run(0, 2, 6, 2, -1, 0, -1, 0, 60);
      chk("R10 swap count", c_ev, 1);
      chk("R10 overrun set", int'(overrun), 1);
      chk("R10 B writes", int'(b_wr && a_rd), 1);
      run(-1, 0, -1, 0, -1, 0, -1, 0, 50);
      chk("R10 overrun sticky", int'(overrun), 1);
   endtask

   task automatic t_fast_reset();
      fr_en = 0;
      run(-1, 0, -1, 0, -1, 0, 0, 2, 30);
      chk("R8 disabled", c_fr, 0);
      fr_en = 1;
      run(-1, 0, -1, 0, -1, 0, 0, 2, 30);
      chk("R8 width", c_fr, 16);
      chk("R8 complement", c_frn_bad, 0);
   endtask

   task automatic t_veto();
      do_reset(0, 0);
      fr_en = 1;
      run(0, 2, -1, 0, -1, 0, -1, 0, 40);
      run(4, 2, -1, 0, -1, 0, 0, 2, 40);
      chk("R9 no valid", c_ev, 0);
      chk("R9 no clear", c_arst + c_brst, 0);
      chk("R9 roles kept", int'(a_wr && !b_wr), 1);
      run(0, 2, -1, 0, -1, 0, -1, 0, 40);
      chk("R9 later event accepted", c_ev, 1);
   endtask

   task automatic t_ext_source();
      do_reset(0, 1);
      run(0, 2, -1, 0, -1, 0, -1, 0, 40);
      chk("R6 trigger ignored", c_arst + c_awr, 0);
      run(-1, 0, -1, 0, 0, 2, -1, 0, 40);
      chk("R6 ext clear", c_arst, 18);
      chk("R6 ext A writes", int'(a_wr), 1);
      run(-1, 0, -1, 0, 0, 2, -1, 0, 40);
      chk("R6 ext swap", c_ev, 1);
      chk("R6 B clear", c_brst, 18);
      chk("R6 buf_sel", int'(buf_sel), 0);
   endtask

   task automatic t_paired();
      do_reset(1, 0);
      run(-1, 0, -1, 0, -1, 0, -1, 0, 5);
      chk("R7 roles", int'({a_wr, b_rd, a_rd, b_wr}), 4'b1100);
      chk("R7 buf_sel", int'(buf_sel), 1);
      run(0, 2, -1, 0, -1, 0, -1, 0, 40);
      chk("R7 trigger ignored", c_arst + c_ev, 0);
      chk("R7 write held", c_awr, 40);
      run(-1, 0, -1, 0, 0, 2, -1, 0, 40);
      chk("R7 A clear", c_arst, 18);
      chk("R7 B clear", c_brst, 18);
      chk("R7 write off during clear", c_awr, 40 - 18);
      chk("R7 write restored", int'(a_wr), 1);
   endtask

   task automatic finish_up();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      rst = 1; trig_in = 0; ext_rst_in = 0; fr_req = 0;
      paired_mode = 0; src_ext = 0; fr_en = 0;
      t_reset_state();
      t_alternate();
      t_long_gap();
      t_held_trigger();
      t_overrun();
      t_fast_reset();
      t_veto();
      t_ext_source();
      t_paired();
      done = 1;
      finish_up();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         finish_up();
      end
   end
endmodule